// File: doc/BRIEF.md
# Software Write Protection Sequencer

This block sits beside a byte-alterable non-volatile memory array. It watches the stream of completed write transactions and decides, for each one, whether the write may reach the array. It recognises two fixed command sequences that are keyed on both address and data. A three-write unlock sequence sets a protection flag and opens a page window for one page load. A six-write disable sequence clears that flag after a fixed programming delay. Once the flag is set, writes outside an open window are discarded, and the programming controller is told not to start a cycle or produce polling status for them.

The protection flag models a non-volatile bit. The power-on reset does not clear it. Only the disable sequence or a dedicated initialisation input clears it. After each page load the block re-arms by itself: the programming-complete pulse closes the window and leaves the flag set. While the flag is clear, every write is an ordinary data write, and that includes the command writes themselves.

Top module: `swp_sequencer`

## Requirements
- R1: The flag is cleared only by `flag_init` or the disable sequence, never by `rst_n`. While it is clear, every write with `wr_valid` high has `wr_permit` high.
- R2: The unlock sequence is 0xAA at 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. Completing it sets the flag from the next cycle, whether the flag was set before or not, and opens the page window. The three unlock writes are permitted only if the flag was clear when they were made.
- R3: Command addresses are matched on address bits 14:0 only. Bits 16 and 15 may hold any value.
- R4: A write that does not continue a partial sequence returns the matcher to idle. If that write is itself 0xAA at 0x5555, it counts as the first step of a new sequence.
- R5: An open window permits at most PAGE_BYTES writes and discards any further ones. Writes made inside the window are never taken as command steps.
- R6: A `prog_done` pulse while the window is open closes the window and leaves the flag set. A `prog_done` pulse while no window is open has no effect.
- R7: While the flag is set and no window is open, `prog_block` is high and every write is discarded. At all other times `prog_block` is low.
- R8: The disable sequence is 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. The flag clears at the WC_CYCLES-th clock edge after the edge that takes the final write. A completed unlock before that edge cancels the pending clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset. Clears the matcher, the window and the pending clear, but not the flag |
| flag_init | input | 1 | Synchronous initialisation that clears the flag and any pending clear |
| wr_valid | input | 1 | One-cycle pulse for a completed write transaction |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| prog_done | input | 1 | Pulse marking the end of a page programming phase |
| wr_permit | output | 1 | The current write may be passed to the array |
| prot_flag | output | 1 | Persistent protection flag |
| prog_block | output | 1 | No programming cycle or polling status may start |

## Verification
The assertions assume that `wr_valid` and `prog_done` are single-cycle pulses sampled on the rising edge, and that `flag_init` is never raised in the same cycle as a completed command. The bench drives inputs only at the falling edge and raises `flag_init` only during idle cycles. Its random phase draws addresses and data mostly from the command keys, with random values in bits 16:15, so that partial, broken and complete sequences all occur. It also injects whole unlock and disable sequences at intervals.

// File: rtl/swp_pkg.sv
package swp_pkg;

  // matcher progress: which command steps have been seen so far
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_K1   = 3'd1,
    ST_K2   = 3'd2,
    ST_D1   = 3'd3,
    ST_D2   = 3'd4,
    ST_D3   = 3'd5
  } seq_st_t;

  localparam int CMD_AW = 15;
  localparam logic [CMD_AW-1:0] KEY_ADDR_HI = 15'h5555;
  localparam logic [CMD_AW-1:0] KEY_ADDR_LO = 15'h2AAA;
  localparam logic [7:0] KEY_D_OPEN  = 8'hAA;
  localparam logic [7:0] KEY_D_CONF  = 8'h55;
  localparam logic [7:0] KEY_D_LOCK  = 8'hA0;
  localparam logic [7:0] KEY_D_ERASE = 8'h80;
  localparam logic [7:0] KEY_D_OFF   = 8'h20;

endpackage

// File: rtl/swp_matcher.sv
module swp_matcher
  import swp_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              unlock_hit,
  output logic              disable_hit
);

  localparam logic [ADDR_W-1:0] CMD_MASK = ADDR_W'({CMD_AW{1'b1}});

  // compare only the low command-address bits and the full data word
  function automatic logic key_is(input logic [ADDR_W-1:0] a,
                                  input logic [DATA_W-1:0] d,
                                  input logic [CMD_AW-1:0] ka,
                                  input logic [7:0] kd);
    return ((a & CMD_MASK) == ADDR_W'(ka)) && (d == DATA_W'(kd));
  endfunction

  seq_st_t st_q, st_d;
  seq_st_t restart;

  always_comb begin
    restart     = key_is(addr, data, KEY_ADDR_HI, KEY_D_OPEN) ? ST_K1 : ST_IDLE;
    st_d        = st_q;
    unlock_hit  = 1'b0;
    disable_hit = 1'b0;
    if (step_en) begin
      unique case (st_q)
        ST_IDLE: st_d = restart;
        ST_K1:   st_d = key_is(addr, data, KEY_ADDR_LO, KEY_D_CONF) ? ST_K2 : restart;
        ST_K2: begin
          if (key_is(addr, data, KEY_ADDR_HI, KEY_D_LOCK)) begin
            unlock_hit = 1'b1;
            st_d       = ST_IDLE;
          end else if (key_is(addr, data, KEY_ADDR_HI, KEY_D_ERASE)) begin
            st_d = ST_D1;
          end else begin
            st_d = restart;
          end
        end
        ST_D1:   st_d = key_is(addr, data, KEY_ADDR_HI, KEY_D_OPEN) ? ST_D2 : restart;
        ST_D2:   st_d = key_is(addr, data, KEY_ADDR_LO, KEY_D_CONF) ? ST_D3 : restart;
        ST_D3: begin
          if (key_is(addr, data, KEY_ADDR_HI, KEY_D_OFF)) begin
            disable_hit = 1'b1;
            st_d        = ST_IDLE;
          end else begin
            st_d = restart;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/swp_window.sv
module swp_window #(
  parameter int PAGE_BYTES = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic open_req,
  input  logic done,
  input  logic wr,
  output logic win_open,
  output logic room
);

  localparam int CNT_W = $clog2(PAGE_BYTES + 1);

  logic [CNT_W-1:0] cnt_q;

  function automatic logic has_room(input logic [CNT_W-1:0] c);
    return c < CNT_W'(PAGE_BYTES);
  endfunction

  assign room = has_room(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_open <= 1'b0;
      cnt_q    <= '0;
    end else if (open_req) begin
      win_open <= 1'b1;
      cnt_q    <= '0;
    end else if (win_open && done) begin
      win_open <= 1'b0;
      cnt_q    <= '0;
    end else if (win_open && wr && room) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/swp_flag.sv
module swp_flag #(
  parameter int WC_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_init,
  input  logic set_req,
  input  logic clr_req,
  output logic flag,
  output logic clr_pend
);

  localparam int TMR_W = $clog2(WC_CYCLES + 1);

  logic [TMR_W-1:0] tmr_q;
  logic             expire;

  assign expire = clr_pend && (tmr_q == TMR_W'(1));

  // the flag models a non-volatile bit: no reset term
  always_ff @(posedge clk) begin
    if (flag_init)    flag <= 1'b0;
    else if (set_req) flag <= 1'b1;
    else if (expire)  flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_pend <= 1'b0;
      tmr_q    <= '0;
    end else if (flag_init || set_req) begin
      clr_pend <= 1'b0;
      tmr_q    <= '0;
    end else if (clr_req) begin
      clr_pend <= 1'b1;
      tmr_q    <= TMR_W'(WC_CYCLES);
    end else if (clr_pend) begin
      clr_pend <= !expire;
      tmr_q    <= tmr_q - TMR_W'(1);
    end
  end

endmodule

// File: rtl/swp_sequencer.sv
module swp_sequencer #(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 256,
  parameter int WC_CYCLES  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flag_init,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              prog_done,
  output logic              wr_permit,
  output logic              prot_flag,
  output logic              prog_block
);

  logic unlock_hit;
  logic disable_hit;
  logic win_open;
  logic win_room;
  logic clr_pend;
  logic step_en;

  assign step_en = wr_valid && !win_open;

  swp_matcher #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_en     (step_en),
    .addr        (wr_addr),
    .data        (wr_data),
    .unlock_hit  (unlock_hit),
    .disable_hit (disable_hit)
  );

  swp_window #(.PAGE_BYTES(PAGE_BYTES)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .open_req (unlock_hit),
    .done     (prog_done),
    .wr       (wr_valid),
    .win_open (win_open),
    .room     (win_room)
  );

  swp_flag #(.WC_CYCLES(WC_CYCLES)) u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .flag_init (flag_init),
    .set_req   (unlock_hit),
    .clr_req   (disable_hit),
    .flag      (prot_flag),
    .clr_pend  (clr_pend)
  );

  assign wr_permit  = wr_valid && (!prot_flag || (win_open && win_room));
  assign prog_block = prot_flag && !win_open;

endmodule

// File: rtl/swp_sequencer_chk.sv
module swp_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic flag_init,
  input logic wr_valid,
  input logic prog_done,
  input logic wr_permit,
  input logic prot_flag,
  input logic unlock_hit,
  input logic win_open,
  input logic clr_pend
);

  AST_CLEAR_PERMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (!prot_flag && wr_valid) |-> wr_permit); // R1

  AST_UNLOCK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock_hit && !flag_init) |=> (prot_flag && win_open)); // R2

  AST_WIN_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n || flag_init)
    win_open |-> prot_flag); // R5

  AST_PERMIT_IN_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_permit && prot_flag) |-> win_open); // R5

  AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_done && win_open && !flag_init) |=> (!win_open && prot_flag)); // R6

  AST_LOCKED_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_flag && !win_open) |-> !wr_permit); // R7

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_flag && !flag_init && !clr_pend) |=> prot_flag); // R8

endmodule

bind swp_sequencer swp_sequencer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flag_init  (flag_init),
  .wr_valid   (wr_valid),
  .prog_done  (prog_done),
  .wr_permit  (wr_permit),
  .prot_flag  (prot_flag),
  .unlock_hit (unlock_hit),
  .win_open   (win_open),
  .clr_pend   (clr_pend)
);

// File: tb/swp_sequencer_test.sv
module swp_sequencer_test;

  localparam int CLK_PERIOD = 10;
  localparam int PAGE = 256;
  localparam int WC   = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flag_init = 1'b0;
  logic        wr_valid = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        prog_done = 1'b0;
  logic        wr_permit, prot_flag, prog_block;

  swp_sequencer #(.ADDR_W(17), .DATA_W(8), .PAGE_BYTES(PAGE), .WC_CYCLES(WC)) uut (
    .clk(clk), .rst_n(rst_n), .flag_init(flag_init), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .prog_done(prog_done),
    .wr_permit(wr_permit), .prot_flag(prot_flag), .prog_block(prog_block)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done_flag = 0;

  // reference state of the bench model
  bit m_flag, m_win, m_pend;
  int m_cnt, m_step, m_tmr;

  // disable path as a table: steps 0..5
  function automatic int seq_a(input int s);
    case (s)
      1, 4:    return 'h2AAA;
      default: return 'h5555;
    endcase
  endfunction

  function automatic int seq_d(input int s);
    case (s)
      0, 3: return 'hAA;
      1, 4: return 'h55;
      2:    return 'h80;
      default: return 'h20;
    endcase
  endfunction

  function automatic bit is_key(input logic [16:0] a, input logic [7:0] d, input int ka, input int kd);
    return (int'(a[14:0]) == ka) && (int'(d) == kd);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_edge(input bit v, input logic [16:0] a, input logic [7:0] d, input bit done);
    bit unl = 0, dis = 0;
    if (v && !m_win) begin
      if (m_step == 2 && is_key(a, d, 'h5555, 'hA0)) begin
        unl = 1; m_step = 0;
      end else if (is_key(a, d, seq_a(m_step), seq_d(m_step))) begin
        if (m_step == 5) begin dis = 1; m_step = 0; end
        else m_step = m_step + 1;
      end else begin
        m_step = is_key(a, d, 'h5555, 'hAA) ? 1 : 0;
      end
    end
    if (unl) begin
      m_flag = 1; m_pend = 0;
    end else if (dis) begin
      m_pend = 1; m_tmr = WC;
    end else if (m_pend) begin
      if (m_tmr == 1) begin m_flag = 0; m_pend = 0; end
      else m_tmr = m_tmr - 1;
    end
    if (unl) begin m_win = 1; m_cnt = 0; end
    else if (m_win && done) begin m_win = 0; m_cnt = 0; end
    else if (m_win && v && m_cnt < PAGE) m_cnt = m_cnt + 1;
  endtask

  // one clock cycle: drive, check outputs against the model, then advance
  task automatic cyc(input bit v, input logic [16:0] a, input logic [7:0] d, input bit done, input string tag);
    bit ep;
    @(negedge clk);
    wr_valid = v; wr_addr = a; wr_data = d; prog_done = done;
    #(CLK_PERIOD/4);
    ep = v && (!m_flag || (m_win && m_cnt < PAGE));
    chk(tag, "wr_permit", int'(wr_permit), int'(ep));
    chk(tag, "prog_block", int'(prog_block), int'(m_flag && !m_win));
    chk(tag, "prot_flag", int'(prot_flag), int'(m_flag));
    @(posedge clk);
    model_edge(v, a, d, done);
    #1;
    wr_valid = 0; prog_done = 0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, '0, '0, 0, tag);
  endtask

  task automatic unlock_seq(input logic [1:0] hi, input string tag);
    cyc(1, {hi, 15'h5555}, 8'hAA, 0, tag);
    cyc(1, {hi, 15'h2AAA}, 8'h55, 0, tag);
    cyc(1, {hi, 15'h5555}, 8'hA0, 0, tag);
  endtask

  task automatic disable_seq(input string tag);
    for (int s = 0; s < 6; s++)
      cyc(1, 17'(seq_a(s)), 8'(seq_d(s)), 0, tag);
  endtask

  task automatic pulse_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_win = 0; m_cnt = 0; m_step = 0; m_pend = 0; m_tmr = 0;
  endtask

  task automatic pulse_init();
    @(negedge clk); flag_init = 1;
    @(posedge clk); #1; flag_init = 0;
    m_flag = 0; m_pend = 0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    m_flag = 0; m_win = 0; m_pend = 0; m_cnt = 0; m_step = 0; m_tmr = 0;
    flag_init = 1;
    repeat (3) @(negedge clk);
    flag_init = 0; rst_n = 1;
    #(CLK_PERIOD/4);
    chk("R1", "reset prot_flag", int'(prot_flag), 0);
    chk("R7", "reset prog_block", int'(prog_block), 0);

    // R1: unprotected data writes pass
    for (int i = 0; i < 8; i++) cyc(1, 17'($urandom), 8'($urandom), 0, "R1");

    // R2 R3: unlock with upper address bits set, from unprotected
    unlock_seq(2'b11, "R3");
    cyc(1, 17'h00100, 8'h11, 0, "R2");
    cyc(1, 17'h00101, 8'h22, 0, "R5");
    cyc(0, '0, '0, 1, "R6");
    cyc(1, 17'h00102, 8'h33, 0, "R7");
    chk("R7", "flag after page", int'(prot_flag), 1);

    // R6: prog_done with no window does nothing
    cyc(0, '0, '0, 1, "R6");
    cyc(1, 17'h00200, 8'h44, 0, "R6");

    // R2 R5: protected unlock, fill the page and overflow it
    unlock_seq(2'b01, "R2");
    cyc(1, 17'h05555, 8'hAA, 0, "R5");
    cyc(1, 17'h02AAA, 8'h55, 0, "R5");
    cyc(1, 17'h05555, 8'hA0, 0, "R5");
    for (int i = 3; i < PAGE + 2; i++) cyc(1, 17'(i), 8'(i), 0, "R5");
    cyc(0, '0, '0, 1, "R6");
    cyc(1, 17'h00010, 8'h01, 0, "R7");

    // R4: broken sequence, then restart through a repeated first step
    cyc(1, 17'h05555, 8'hAA, 0, "R4");
    cyc(1, 17'h02AAA, 8'h55, 0, "R4");
    cyc(1, 17'h01234, 8'h00, 0, "R4");
    cyc(1, 17'h05555, 8'hA0, 0, "R4");
    cyc(1, 17'h00300, 8'h77, 0, "R4");
    cyc(1, 17'h05555, 8'hAA, 0, "R4");
    cyc(1, 17'h05555, 8'hAA, 0, "R4");
    cyc(1, 17'h02AAA, 8'h55, 0, "R4");
    cyc(1, 17'h05555, 8'hA0, 0, "R4");
    cyc(1, 17'h00300, 8'h78, 0, "R4");
    cyc(0, '0, '0, 1, "R4");

    // R1: the flag survives the power-on reset
    pulse_reset();
    cyc(1, 17'h00400, 8'h99, 0, "R1");
    chk("R1", "flag across reset", int'(prot_flag), 1);

    // R8: disable, flag clears exactly WC edges after the last write
    disable_seq("R8");
    idle(WC - 1, "R8");
    chk("R8", "flag before expiry", int'(prot_flag), 1);
    cyc(0, '0, '0, 0, "R8");
    chk("R8", "flag after expiry", int'(prot_flag), 0);
    cyc(1, 17'h00500, 8'h5A, 0, "R8");

    // R8: an unlock cancels a pending clear
    unlock_seq(2'b00, "R8");
    cyc(0, '0, '0, 1, "R8");
    disable_seq("R8");
    idle(3, "R8");
    unlock_seq(2'b10, "R8");
    idle(WC + 4, "R8");
    chk("R8", "flag kept after cancel", int'(prot_flag), 1);
    cyc(0, '0, '0, 1, "R8");

    // R1: initialisation input clears the flag
    pulse_init();
    cyc(1, 17'h00600, 8'h66, 0, "R1");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [16:0] a;
      logic [7:0] d;
      r = int'($urandom % 16);
      if (n % 300 == 17) unlock_seq(2'($urandom), "rand_r2");
      if (n % 700 == 351) disable_seq("rand_r8");
      a = {2'($urandom), (($urandom % 2) == 0) ? 15'h5555 : 15'h2AAA};
      case ($urandom % 5)
        0: d = 8'hAA;
        1: d = 8'h55;
        2: d = 8'hA0;
        3: d = 8'h80;
        default: d = 8'h20;
      endcase
      if (r >= 9) begin
        a = 17'($urandom);
        d = 8'($urandom);
      end
      cyc(($urandom % 4) != 0, a, d, ($urandom % 24) == 0, "rand_r4");
    end

    finish_run();
  end

endmodule